// File: doc/BRIEF.md
# Configurable UART Transmitter

This block turns one character per request into an asynchronous serial frame on a single TX line. A character may be 7, 8 or 9 bits wide. Parity (odd or even) is optional, the frame ends with one or two stop bits, and the line level can be inverted. The frame, the divider value and the inversion setting are all captured when a request is accepted, so the transmission in progress is fixed from then on.

Bit timing comes from a count source that the surrounding logic provides as a one-cycle clock enable. An 8-bit reload divider with value n passes one pulse for every n + 1 enabled cycles. A further fixed divide-by-16 stage turns those pulses into bit periods. `busy_o` covers the whole frame, and `done_o` marks its end with a single-cycle pulse.

Top module: `uart_tx_cfg`

## Requirements
- R1: With divider value n (0 to 255) and the count source enabled on every cycle, each frame bit lasts exactly 16*(n+1) clock cycles.
- R2: mode_i selects the character length: 3'b100 gives 7 bits, 3'b101 gives 8 bits and 3'b110 gives 9 bits. Every other code, 3'b000 included, means disabled, and a start request is then ignored: busy_o stays low and tx_o stays at the idle level.
- R3: The frame, before any inversion, is a low start bit, then the data bits with bit 0 first, then the parity bit if enabled, then the stop bits, which are high.
- R4: stop2_i = 0 gives one stop bit and stop2_i = 1 gives two.
- R5: When par_en_i = 1, a parity bit follows the data. With par_even_i = 0 (odd), the data ones plus the parity bit add up to an odd count. With par_even_i = 1 (even), they add up to an even count. When par_en_i = 0, par_even_i has no effect on the frame.
- R6: When inv_i = 1 every level on tx_o is inverted, the idle level included. When inv_i = 0 the idle level is high.
- R7: busy_o rises on the clock edge that accepts start_i. It stays high until the last stop bit ends. On that edge busy_o falls and done_o is high for exactly one cycle.
- R8: While busy_o is high, start_i and any change to mode_i, div_i, inv_i or the frame options do not affect the frame in progress.
- R9: In 7-bit mode data_i[8:7] are ignored, and in 8-bit mode data_i[8] is ignored.
- R10: Bit timing counts only cycles in which cnt_en_i is high. When cnt_en_i is high on every other cycle, the frame takes twice as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one character |
| data_i | input | 9 | Character to send, bit 0 sent first |
| mode_i | input | 3 | Character length code or disabled |
| stop2_i | input | 1 | 1 selects two stop bits |
| par_en_i | input | 1 | Enables the parity bit |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| inv_i | input | 1 | Inverts the TX line level |
| div_i | input | 8 | Reload divider value n |
| cnt_en_i | input | 1 | Count source enable |
| tx_o | output | 1 | Serial output line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The hardest case to reach is a frame that is already under way when its settings change. To reach it, the stimulus waits until the second bit period. It then changes the mode to disabled, toggles inversion, zeroes the divider and sends a second start request. After that it checks every remaining bit of the first frame against the settings captured at its start. Other stimulus covers the largest divider value, where one frame lasts tens of thousands of cycles, and a count source enabled on every other cycle, where the bench checks that the frame takes twice as long.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int DIV_W   = 8;
  localparam int OVS     = 16;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [2:0] MODE_C7 = 3'b100;
  localparam logic [2:0] MODE_C8 = 3'b101;
  localparam logic [2:0] MODE_C9 = 3'b110;

  // 0 marks a disabled or unsupported code
  function automatic logic [3:0] char_len(input logic [2:0] m);
    case (m)
      MODE_C7: return 4'd7;
      MODE_C8: return 4'd8;
      MODE_C9: return 4'd9;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int OVS_W = $clog2(OVS);

  logic [DIV_W-1:0] pre_q;
  logic [OVS_W-1:0] sub_q;
  logic             pre_wrap;

  assign pre_wrap = en_i && (pre_q == div_i);
  assign tick_o   = pre_wrap && (sub_q == OVS_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (en_i) begin
      if (pre_wrap) begin
        pre_q <= '0;
        sub_q <= tick_o ? '0 : sub_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data_i,
  input  logic [3:0]         len_i,
  input  logic               par_en_i,
  input  logic               par_even_i,
  input  logic               stop2_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);
  logic [DATA_W-1:0] dm;
  logic              par;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) dm[i] = (i < int'(len_i)) ? data_i[i] : 1'b0;
    par = (^dm) ^ ~par_even_i;
    frame_o = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(len_i)) frame_o[1+i] = dm[i];
    if (par_en_i) frame_o[CNT_W'(len_i) + 1'b1] = par;
    nbits_o = CNT_W'(len_i) + CNT_W'(2) + CNT_W'(par_en_i) + CNT_W'(stop2_i);
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               tick_i,
  output logic               line_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q, last_q;

  assign line_o = sr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      last_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (load_i) begin
      sr_q   <= frame_i;
      cnt_q  <= '0;
      last_q <= nbits_i - 1'b1;
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_o && tick_i) begin
        if (cnt_q == last_q) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          sr_q   <= '1;
        end else begin
          sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        mode_i,
  input  logic              stop2_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              inv_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cnt_en_i,
  output logic              tx_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [3:0]         len;
  logic               load;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic [DIV_W-1:0]   div_q;
  logic               inv_q;
  logic               tick, line;

  assign len  = char_len(mode_i);
  assign load = start_i && !busy_o && (len != 4'd0);

  // settings captured once per frame; later changes wait for idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      inv_q <= 1'b0;
    end else if (load) begin
      div_q <= div_i;
      inv_q <= inv_i;
    end
  end

  uart_tx_frame u_frame (
    .data_i(data_i), .len_i(len), .par_en_i(par_en_i), .par_even_i(par_even_i),
    .stop2_i(stop2_i), .frame_o(frame), .nbits_o(nbits)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .en_i(cnt_en_i && busy_o),
    .div_i(div_q), .tick_o(tick)
  );

  uart_tx_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .frame_i(frame), .nbits_i(nbits),
    .tick_i(tick), .line_o(line), .busy_o(busy_o), .done_o(done_o)
  );

  assign tx_o = busy_o ? (line ^ inv_q) : ~inv_i;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [2:0] mode_i,
  input logic       inv_i,
  input logic       cnt_en_i,
  input logic       tx_o,
  input logic       busy_o,
  input logic       done_o
);
  logic mode_ok;
  assign mode_ok = (mode_i == 3'b100) || (mode_i == 3'b101) || (mode_i == 3'b110);

  p_done_ends_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_needs_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && $past(mode_ok)));

  p_start_bit_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (tx_o == $past(inv_i)));

  p_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (tx_o == ~inv_i));

  p_gated_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(cnt_en_i)) |-> $stable(tx_o));
endmodule

bind uart_tx_cfg uart_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
  .inv_i(inv_i), .cnt_en_i(cnt_en_i), .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/uart_tx_cfg_bench.sv
module uart_tx_cfg_bench;
  localparam int CLK_T = 10;
  localparam int NV = 8;
  // {mode, stop2, par_en, par_even, inv, div, data}
  localparam logic [23:0] VEC [NV] = '{
    {3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 9'h0A5},
    {3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 9'h1FF},
    {3'b110, 1'b1, 1'b1, 1'b1, 1'b0, 8'd2, 9'h155},
    {3'b101, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0, 9'h03C},
    {3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 8'd3, 9'h180},
    {3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 9'h1FF},
    {3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 9'h000},
    {3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 9'h1FF}
  };

  logic clk = 0, rst_n = 0, start = 0, stop2 = 0, par_en = 0, par_even = 0, inv = 0;
  logic [8:0] data = '0;
  logic [2:0] mode = 3'b101;
  logic [7:0] div = '0;
  logic cnt_en = 1, gate = 0;
  logic tx, busy, done;
  int tests = 0, fails = 0;

  always #(CLK_T/2) clk = ~clk;
  always @(negedge clk) cnt_en <= gate ? ~cnt_en : 1'b1;

  uart_tx_cfg u_uart_tx_cfg (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .data_i(data), .mode_i(mode),
    .stop2_i(stop2), .par_en_i(par_en), .par_even_i(par_even), .inv_i(inv),
    .div_i(div), .cnt_en_i(cnt_en), .tx_o(tx), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // disturb: change every setting and re-request start during the second bit
  task automatic run_frame(input logic [23:0] v, input bit disturb, input string req);
    logic [12:0] bits;
    int len, nb, p, k_done;
    logic [8:0] dm;
    logic [2:0] m0;
    logic i0;
    {m0, stop2, par_en, par_even, inv, div, data} = v;
    mode = m0; i0 = inv;
    len = (m0 == 3'b100) ? 7 : (m0 == 3'b101) ? 8 : 9;
    dm = data & ((9'd1 << len) - 9'd1);
    bits = '1; bits[0] = 1'b0;
    for (int i = 0; i < len; i++) bits[1+i] = dm[i];
    nb = 1 + len;
    if (par_en) begin
      bits[nb] = par_even ? (^dm) : ~(^dm);
      nb++;
    end
    nb += stop2 ? 2 : 1;
    p = 16 * (int'(div) + 1);
    start = 1;
    @(posedge clk);
    k_done = nb * p + 1;
    for (int k = 1; k <= k_done; k++) begin
      @(negedge clk);
      if (k == 1) start = 0;
      if (disturb && k == p + 3) begin
        mode = 3'b000; inv = ~i0; div = 8'd0; stop2 = ~stop2; start = 1;
      end
      if (disturb && k == p + 4) begin
        start = 0; mode = 3'b101;
      end
      if (k == 1) check("R7", "busy after start", busy, 1);
      if ((k % p) == p / 2 && k / p < nb)
        check(req, $sformatf("bit %0d", k / p), tx, bits[k / p] ^ i0);
      if (k == k_done - 1) check("R1", "busy before end", busy, 1);
      if (k == k_done) begin
        check("R7", "done at end", done, 1);
        check("R7", "busy at end", busy, 0);
      end
    end
    @(negedge clk);
    check("R7", "done one cycle", done, 0);
    inv = 0; stop2 = 0; mode = 3'b101;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6", "reset tx", tx, 1);
    check("R7", "reset busy", busy, 0);
    check("R7", "reset done", done, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_frame(VEC[i], 0, "R3 R4 R5 R9");

    // R6: idle inversion
    inv = 1; @(negedge clk);
    check("R6", "idle inverted", tx, 0);
    inv = 0; @(negedge clk);
    check("R6", "idle plain", tx, 1);

    // R2: disabled codes ignore start
    foreach (VEC[i]) begin
      if (i < 3) begin
        mode = (i == 0) ? 3'b000 : (i == 1) ? 3'b011 : 3'b111;
        start = 1; @(negedge clk); start = 0;
        repeat (20) @(negedge clk);
        check("R2", $sformatf("disabled busy code %0d", mode), busy, 0);
        check("R2", "disabled tx idle", tx, 1);
      end
    end
    mode = 3'b101;

    // R8: changes while busy
    run_frame({3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2, 9'h0C3}, 1, "R8");

    // R1: largest divider
    run_frame({3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 8'd255, 9'h055}, 0, "R1");

    // R10: count source enabled every other cycle
    begin
      int n;
      gate = 1; mode = 3'b101; div = 8'd3; data = 9'h5A; par_en = 0; stop2 = 0;
      @(negedge clk);
      start = 1; @(posedge clk); @(negedge clk); start = 0;
      n = 1;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      tests++;
      if (n < 2 * 10 * 64 - 2 || n > 2 * 10 * 64 + 2) begin
        fails++;
        $display("FAIL R10 gated frame length: got %0d expected %0d", n, 2 * 10 * 64);
      end
      gate = 0;
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule